// File: doc/BRIEF.md
# Dual-radix carry-save sum checker

This block watches an adder/subtractor that it does not contain. The adder works either in BCD ten's complement or in plain two's complement, over P four-bit digits. The checker takes the adder's two operands, the result the adder produced, the subtract request and the radix select. It raises a flag when that result cannot be the correct add or subtract under the selected radix. It never redoes the addition with a full carry chain.

Each digit of the second operand is first biased: it is inverted for subtract, or raised by six for decimal add. For every digit the block then forms a generate bit and an alive bit. A parallel-prefix network over those bits gives the decimal carry into each digit, with the subtract request as the carry into digit 0. From these carries the block undoes the six-bias where no decimal carry leaves the digit. It also remaps the result digit where the digit pair sums to exactly nine. The first operand, the adjusted second operand and the complemented adjusted result then go through one row of 3:2 compressors. The word passes when the compressor's sum vector and its shifted carry vector are bitwise complements, which means the three addends total all ones.

The flag is registered once, behind a synchronous active-high reset. The check itself is purely combinational.

Top module: `dual_radix_sum_checker`

## Requirements
- R1: While `rst` is high at a rising edge, `err` reads 0 after that edge, whatever the data inputs are.
- R2: `err` reflects the inputs sampled at the previous rising edge. A change of the inputs between edges does not alter `err` until the next edge.
- R3: With `dec`=0 and `sub`=0, `err` is 0 when `sum_in` equals `opa + opb` modulo 2^(4P).
- R4: With `dec`=0 and `sub`=1, `err` is 0 when `sum_in` equals `opa - opb` modulo 2^(4P).
- R5: With `dec`=0, `err` is 1 for any `sum_in` that differs from the R3/R4 result, including every single-bit flip of the correct result.
- R6: With `dec`=1 and `sub`=0, and BCD operands (digit i at bits 4i+3..4i, values 0-9), `err` is 0 when `sum_in` is the BCD sum modulo 10^P.
- R7: With `dec`=1 and `sub`=1, `err` is 0 when `sum_in` is the BCD difference `opa - opb` modulo 10^P (ten's complement).
- R8: With `dec`=1, every single-bit flip of the correct BCD result gives `err`=1.
- R9: Digits whose operand pair sums to exactly nine are checked correctly for both incoming carry values. This covers all-nines results, full carry ripples to zero and x-minus-x. A result that swaps 9 and 0 in such a digit gives `err`=1.
- R10: `dec` selects the arithmetic. A result that is right only under the other radix gives `err`=1.
- R11: The carry into digit 0 equals `sub`. A subtract result that is missing the +1 of the complement gives `err`=1 in both radices.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the flag register |
| rst | input | 1 | Synchronous active-high reset, clears `err` |
| opa | input | 4*P | First operand of the checked operation |
| opb | input | 4*P | Second operand (subtrahend when `sub`=1) |
| sum_in | input | 4*P | Result produced by the adder under check |
| sub | input | 1 | 1 = subtract, 0 = add |
| dec | input | 1 | 1 = BCD ten's complement, 0 = binary two's complement |
| err | output | 1 | Registered mismatch flag |

## Verification
The bench goes after digits whose pair sums to exactly nine. A checker that remaps the result digit without regard to the incoming carry would accept a 0 in place of a 9, or reject a correct 0 after a carry ripple. Single-bit flips of every result bit, in both radices, expose a remap that is not one-to-one or a six-bias left in place. Subtract results that lack the +1 of the complement show whether the carry into digit 0 is tied to `sub`. Feeding a decimal-correct result in binary mode, and the reverse, catches a radix select that fails to gate the corrections.

// File: rtl/sumchk_pkg.sv
package sumchk_pkg;

    localparam int DIGIT_W = 4;

    typedef logic [DIGIT_W-1:0] nib_t;

    // generate / alive pair of one radix-16 digit position
    typedef struct packed {
        logic gen;
        logic alive;
    } gp_t;

    // bias the second operand digit before the digit-pair sum
    function automatic nib_t bias_digit(nib_t y, logic sub, logic dec);
        nib_t r;
        if (sub)
            r = ~y;
        else if (dec)
            r = y + nib_t'(6);
        else
            r = y;
        return r;
    endfunction

    function automatic gp_t pair_flags(nib_t x, nib_t yb);
        logic [DIGIT_W:0] t;
        gp_t r;
        t = {1'b0, x} + {1'b0, yb};
        r.gen   = (t >= 5'd16);
        r.alive = (t >= 5'd15);
        return r;
    endfunction

    // combine a more significant group (hi) with a less significant one (lo)
    function automatic gp_t gp_merge(gp_t hi, gp_t lo);
        gp_t r;
        r.gen   = hi.gen | (hi.alive & lo.gen);
        r.alive = hi.alive & lo.alive;
        return r;
    endfunction

endpackage

// File: rtl/sumchk_digit_front.sv
module sumchk_digit_front
    import sumchk_pkg::*;
#(
    parameter int P = 16,
    localparam int W = P * DIGIT_W
) (
    input  logic [W-1:0]  opa,
    input  logic [W-1:0]  opb,
    input  logic          sub,
    input  logic          dec,
    output logic [W-1:0]  opb_bias,
    output gp_t  [P-1:0]  flags
);

    for (genvar i = 0; i < P; i++) begin : g_dig
        nib_t yb;
        assign yb = bias_digit(opb[i*DIGIT_W +: DIGIT_W], sub, dec);
        assign opb_bias[i*DIGIT_W +: DIGIT_W] = yb;
        assign flags[i] = pair_flags(opa[i*DIGIT_W +: DIGIT_W], yb);
    end

endmodule

// File: rtl/sumchk_prefix.sv
module sumchk_prefix
    import sumchk_pkg::*;
#(
    parameter int N = 15,
    localparam int LV = (N > 1) ? $clog2(N) : 0
) (
    input  gp_t  [N-1:0] flags,
    input  logic         cin,
    output logic [N:0]   carry
);

    gp_t [N-1:0] stage [LV+1];

    assign stage[0] = flags;

    // Kogge-Stone span doubling
    for (genvar lv = 0; lv < LV; lv++) begin : g_lvl
        for (genvar i = 0; i < N; i++) begin : g_pos
            if (i >= (1 << lv)) begin : g_mrg
                assign stage[lv+1][i] = gp_merge(stage[lv][i], stage[lv][i-(1<<lv)]);
            end else begin : g_pass
                assign stage[lv+1][i] = stage[lv][i];
            end
        end
    end

    assign carry[0] = cin;
    for (genvar i = 0; i < N; i++) begin : g_cout
        assign carry[i+1] = stage[LV][i].gen | (stage[LV][i].alive & cin);
    end

endmodule

// File: rtl/sumchk_digit_adjust.sv
module sumchk_digit_adjust
    import sumchk_pkg::*;
#(
    parameter int P = 16,
    localparam int W = P * DIGIT_W
) (
    input  logic [W-1:0]  opb_bias,
    input  gp_t  [P-1:0]  flags,
    input  logic [P-1:0]  carry,
    input  logic [W-1:0]  sum_in,
    input  logic          dec,
    output logic [W-1:0]  opb_final,
    output logic [W-1:0]  sum_addend
);

    for (genvar i = 0; i < P; i++) begin : g_dig
        nib_t yb;
        nib_t sd;
        nib_t sd_adj;
        logic nine_pos;

        assign yb = opb_bias[i*DIGIT_W +: DIGIT_W];
        assign sd = sum_in[i*DIGIT_W +: DIGIT_W];
        // pair sums to exactly nine in decimal mode
        assign nine_pos = dec & flags[i].alive & ~flags[i].gen;

        always_comb begin
            if (dec && !flags[i].alive)
                opb_final[i*DIGIT_W +: DIGIT_W] = yb - nib_t'(6);
            else
                opb_final[i*DIGIT_W +: DIGIT_W] = yb;

            // with no carry in, the expected digit 9 is moved onto 15
            if (nine_pos && !carry[i])
                sd_adj = sd + nib_t'(6);
            else
                sd_adj = sd;
        end

        assign sum_addend[i*DIGIT_W +: DIGIT_W] = ~sd_adj;
    end

endmodule

// File: rtl/sumchk_allones.sv
module sumchk_allones #(
    parameter int W = 64
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] c,
    input  logic         cin,
    output logic [W-1:0] miss
);

    logic [W-1:0] sv;
    logic [W-1:0] maj;
    logic [W-1:0] cv;

    assign sv  = a ^ b ^ c;
    assign maj = (a & b) | (a & c) | (b & c);

    if (W > 1) begin : g_shift
        assign cv = {maj[W-2:0], cin};
    end else begin : g_one
        assign cv = cin;
    end

    // sv + cv equals all ones exactly when the two vectors are complements
    assign miss = ~(sv ^ cv);

endmodule

// File: rtl/dual_radix_sum_checker.sv
module dual_radix_sum_checker
    import sumchk_pkg::*;
#(
    parameter int P = 16,
    localparam int W = P * DIGIT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [W-1:0]  opa,
    input  logic [W-1:0]  opb,
    input  logic [W-1:0]  sum_in,
    input  logic          sub,
    input  logic          dec,
    output logic          err
);

    logic [W-1:0] opb_bias;
    logic [W-1:0] opb_final;
    logic [W-1:0] sum_addend;
    logic [W-1:0] miss;
    logic [P-1:0] carry;
    gp_t  [P-1:0] flags;
    logic         err_d;

    sumchk_digit_front #(.P(P)) u_front (
        .opa      (opa),
        .opb      (opb),
        .sub      (sub),
        .dec      (dec),
        .opb_bias (opb_bias),
        .flags    (flags)
    );

    if (P > 1) begin : g_pfx
        sumchk_prefix #(.N(P-1)) u_prefix (
            .flags (flags[P-2:0]),
            .cin   (sub),
            .carry (carry)
        );
    end else begin : g_nopfx
        assign carry = sub;
    end

    sumchk_digit_adjust #(.P(P)) u_adjust (
        .opb_bias   (opb_bias),
        .flags      (flags),
        .carry      (carry),
        .sum_in     (sum_in),
        .dec        (dec),
        .opb_final  (opb_final),
        .sum_addend (sum_addend)
    );

    sumchk_allones #(.W(W)) u_csa (
        .a    (opa),
        .b    (opb_final),
        .c    (sum_addend),
        .cin  (sub),
        .miss (miss)
    );

    assign err_d = |miss;

    always_ff @(posedge clk) begin
        if (rst)
            err <= 1'b0;
        else
            err <= err_d;
    end

endmodule

// File: rtl/sumchk_checker.sv
module sumchk_checker #(
    parameter int P = 16,
    localparam int W = P * 4
) (
    input logic          clk,
    input logic          rst,
    input logic [W-1:0]  opa,
    input logic [W-1:0]  opb,
    input logic [W-1:0]  sum_in,
    input logic          sub,
    input logic          dec,
    input logic          err
);

    logic [W-1:0] bin_add;
    logic [W-1:0] bin_sub;
    assign bin_add = opa + opb;
    assign bin_sub = opa - opb;

    assert_quiet_in_reset_R1: assert property (@(posedge clk)
        rst |=> !err);

    assert_bin_add_clean_R3: assert property (@(posedge clk) disable iff (rst)
        (!dec && !sub && sum_in == bin_add) |=> !err);

    assert_bin_sub_clean_R4: assert property (@(posedge clk) disable iff (rst)
        (!dec && sub && sum_in == bin_sub) |=> !err);

    assert_bin_wrong_flagged_R5: assert property (@(posedge clk) disable iff (rst)
        (!dec && sum_in != (sub ? bin_sub : bin_add)) |=> err);

endmodule

bind dual_radix_sum_checker sumchk_checker #(.P(P)) u_sumchk_checker (
    .clk    (clk),
    .rst    (rst),
    .opa    (opa),
    .opb    (opb),
    .sum_in (sum_in),
    .sub    (sub),
    .dec    (dec),
    .err    (err)
);

// File: tb/tb_dual_radix_sum_checker.sv
`timescale 1ns/1ps
module tb_dual_radix_sum_checker;

    localparam int P = 16;
    localparam int W = 4 * P;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] opa = '0;
    logic [W-1:0] opb = '0;
    logic [W-1:0] sum_in = '0;
    logic         sub = 1'b0;
    logic         dec = 1'b0;
    logic         err;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #2 clk = ~clk;

    dual_radix_sum_checker #(.P(P)) dut (
        .clk(clk), .rst(rst), .opa(opa), .opb(opb),
        .sum_in(sum_in), .sub(sub), .dec(dec), .err(err)
    );

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    function automatic logic [W-1:0] bcd_rand();
        logic [W-1:0] r;
        for (int d = 0; d < P; d++) r[4*d +: 4] = 4'($urandom_range(0, 9));
        return r;
    endfunction

    function automatic logic [W-1:0] bcd_ref(input logic [W-1:0] a, input logic [W-1:0] b,
                                              input logic sb, input logic ci);
        logic [W-1:0] r;
        int c = int'(ci);
        for (int d = 0; d < P; d++) begin
            int xd = int'(a[4*d +: 4]);
            int yd = sb ? 9 - int'(b[4*d +: 4]) : int'(b[4*d +: 4]);
            int t = xd + yd + c;
            r[4*d +: 4] = 4'(t % 10);
            c = (t >= 10) ? 1 : 0;
        end
        return r;
    endfunction

    function automatic logic [W-1:0] bin_ref(input logic [W-1:0] a, input logic [W-1:0] b,
                                              input logic sb);
        return sb ? a - b : a + b;
    endfunction

    task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b, input logic [W-1:0] s,
                         input logic sb, input logic dc, output logic e);
        @(negedge clk);
        opa = a; opb = b; sum_in = s; sub = sb; dec = dc;
        @(negedge clk);
        e = err;
    endtask

    task automatic expect_vec(input string tag, input logic [W-1:0] a, input logic [W-1:0] b,
                              input logic [W-1:0] s, input logic sb, input logic dc,
                              input logic exp);
        logic e;
        apply(a, b, s, sb, dc, e);
        check(tag, e, exp);
    endtask

    task automatic flip_all(input string tag, input logic [W-1:0] a, input logic [W-1:0] b,
                            input logic [W-1:0] s, input logic sb, input logic dc);
        for (int k = 0; k < W; k++)
            expect_vec(tag, a, b, s ^ (64'd1 << k), sb, dc, 1'b1);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        @(negedge clk);
        opa = 64'h5; opb = 64'h3; sum_in = 64'h77; sub = 0; dec = 0;
        @(negedge clk);
        check("R1 err during reset, wrong sum", err, 1'b0);
        @(negedge clk);
        check("R1 err held low in reset", err, 1'b0);
        rst = 1'b0;
        expect_vec("R1 first checked cycle, correct sum", 64'h5, 64'h3, 64'h8, 0, 0, 1'b0);
    endtask

    task automatic t_latency();
        expect_vec("R2 wrong sum registered", 64'h10, 64'h20, 64'h31, 0, 0, 1'b1);
        @(negedge clk);
        sum_in = 64'h30;
        #1;
        check("R2 flag unchanged before edge", err, 1'b1);
        @(negedge clk);
        check("R2 flag follows after edge", err, 1'b0);
    endtask

    task automatic t_binary(input logic sb);
        for (int n = 0; n < 6; n++) begin
            logic [W-1:0] a = {$urandom, $urandom};
            logic [W-1:0] b = {$urandom, $urandom};
            logic [W-1:0] s = bin_ref(a, b, sb);
            expect_vec(sb ? "R4 binary sub correct" : "R3 binary add correct", a, b, s, sb, 0, 1'b0);
            flip_all("R5 binary flipped bit", a, b, s, sb, 0);
            expect_vec("R5 binary random wrong", a, b, s + 64'd1234567, sb, 0, 1'b1);
        end
        expect_vec(sb ? "R4 binary sub wrap" : "R3 binary add wrap",
                   64'hFFFF_FFFF_FFFF_FFFF, 64'h1, bin_ref(64'hFFFF_FFFF_FFFF_FFFF, 64'h1, sb),
                   sb, 0, 1'b0);
    endtask

    task automatic t_decimal(input logic sb);
        for (int n = 0; n < 6; n++) begin
            logic [W-1:0] a = bcd_rand();
            logic [W-1:0] b = bcd_rand();
            logic [W-1:0] s = bcd_ref(a, b, sb, sb);
            expect_vec(sb ? "R7 decimal sub correct" : "R6 decimal add correct", a, b, s, sb, 1, 1'b0);
            flip_all("R8 decimal flipped bit", a, b, s, sb, 1);
        end
    endtask

    task automatic t_nines();
        logic [W-1:0] a;
        logic [W-1:0] b;
        logic [W-1:0] s;
        a = bcd_rand();
        for (int d = 0; d < P; d++) b[4*d +: 4] = 4'(9 - int'(a[4*d +: 4]));
        s = bcd_ref(a, b, 0, 0);
        check("R9 reference all nines", 1'(s == 64'h9999_9999_9999_9999), 1'b1);
        expect_vec("R9 all-nines add, no carry", a, b, s, 0, 1, 1'b0);
        flip_all("R9 all-nines flipped bit", a, b, s, 0, 1);
        expect_vec("R9 nine replaced by zero", a, b, s & ~64'hF0, 0, 1, 1'b1);
        // full ripple to zero
        a[3:0] = (a[3:0] == 4'd0) ? 4'd1 : a[3:0];
        b[3:0] = 4'(10 - int'(a[3:0]));
        s = bcd_ref(a, b, 0, 0);
        expect_vec("R9 ripple to zero correct", a, b, s, 0, 1, 1'b0);
        expect_vec("R9 ripple, zero replaced by nine", a, b, s | 64'h900, 0, 1, 1'b1);
        expect_vec("R9 ripple ignored (all nines)", a, b, 64'h9999_9999_9999_9990, 0, 1, 1'b1);
        flip_all("R9 ripple flipped bit", a, b, s, 0, 1);
        // x - x
        a = bcd_rand();
        expect_vec("R9 x minus x is zero", a, a, 64'h0, 1, 1, 1'b0);
        flip_all("R9 x minus x flipped bit", a, a, 64'h0, 1, 1);
        expect_vec("R9 x minus x as all nines", a, a, 64'h9999_9999_9999_9999, 1, 1, 1'b1);
    endtask

    task automatic t_mode();
        expect_vec("R10 decimal result in binary mode", 64'h5, 64'h5, 64'h10, 0, 0, 1'b1);
        expect_vec("R10 binary result in decimal mode", 64'h5, 64'h5, 64'hA, 0, 1, 1'b1);
        expect_vec("R10 decimal add in decimal mode", 64'h5, 64'h5, 64'h10, 0, 1, 1'b0);
        expect_vec("R10 decimal sub in binary mode", 64'h10, 64'h1, 64'h9, 1, 0, 1'b1);
        expect_vec("R10 decimal sub in decimal mode", 64'h10, 64'h1, 64'h9, 1, 1, 1'b0);
    endtask

    task automatic t_lsd();
        for (int n = 0; n < 4; n++) begin
            logic [W-1:0] a = bcd_rand();
            logic [W-1:0] b = bcd_rand();
            logic [W-1:0] ba = {$urandom, $urandom};
            logic [W-1:0] bb = {$urandom, $urandom};
            expect_vec("R11 decimal sub missing +1", a, b, bcd_ref(a, b, 1, 0), 1, 1, 1'b1);
            expect_vec("R11 decimal add with stray +1", a, b, bcd_ref(a, b, 0, 1), 0, 1, 1'b1);
            expect_vec("R11 binary sub missing +1", ba, bb, ba + ~bb, 1, 0, 1'b1);
        end
    endtask

    initial begin
        t_reset();
        t_latency();
        t_binary(1'b0);
        t_binary(1'b1);
        t_decimal(1'b0);
        t_decimal(1'b1);
        t_nines();
        t_mode();
        t_lsd();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule